// File: doc/BRIEF.md
# Programmable Interval Clock

A 16-bit programmable real-time clock that sits on a simple word-wide register bus. Software loads a count preset, chooses one of four tick sources, a direction and a single-shot or repeat mode, then sets the run bit. On every strobe from the selected tick source the counter takes one step. When it reaches zero the block raises a done flag and, if enabled, a level interrupt request. A second terminal count before software has read status raises an overrun error flag instead. Reading status clears the flags and the request.

The tick sources are single-cycle enable strobes generated outside the block, one per rate code. While the clock is stopped, software can step the counter by hand through a strobe bit in the control word. Bus reads return data combinationally in the access cycle. Every side effect of an access takes place at the clock edge that ends that cycle.

Top module: `prog_interval_clock`

## Requirements
- R1: After reset all registers read zero and `irq_o` is low.
- R2: Word address 0 reads the control word: bit 15 = error, bit 7 = done, bit 6 = interrupt enable, bit 5 always 0, bit 4 = count up, bit 3 = repeat, bits 2:1 = rate code, bit 0 = run, and all other bits 0. Address 1 (preset) and address 3 read 0. Address 2 reads the live counter.
- R3: A control write replaces run, rate, repeat, up and interrupt enable from write bits 0, 2:1, 3, 4 and 6. It also clears done, error and the interrupt request.
- R4: A control read returns the current value, then clears done, error and the interrupt request at the end of the cycle.
- R5: A preset write (address 1) stores the value, loads it into the counter and clears done, error and the interrupt request. Writes to address 2 leave the counter unchanged.
- R6: While run is 1, a strobe on `tick_i[rate]` decrements the counter (up = 0) or increments it (up = 1). Strobes on other lines have no effect. A strobe in a cycle with a control or preset write is ignored.
- R7: Terminal count is a step that makes the counter zero. At terminal count, error is set if done is already 1; otherwise done is set. If interrupt enable is 1, the interrupt request is raised.
- R8: After terminal count in repeat mode the counter reloads from the preset and keeps running. In single mode, run, the preset and the counter all become 0.
- R9: A control write that sets run while run was 0, or that changes the rate with run kept at 1, reloads the counter from the preset.
- R10: A control write with run = 0 and bit 5 = 1 steps the counter once, in the direction given by the written up bit. If that step reaches zero, terminal count behaviour follows, using the written mode and interrupt enable.
- R11: A preset of 0 counting down gives a full interval of 65536 ticks. Counting up from value v reaches terminal count after 65536 - v ticks.
- R12: If terminal count happens in the same cycle as a clearing access, the clear applies first: done ends at 1, error at 0, and the request is raised if interrupt enable is 1.
- R13: `irq_o` is a level. Once raised, it stays high until a control read, a control write or a preset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address (register select) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the access cycle |
| tick_i | input | 4 | Tick strobes, index = rate code |
| irq_o | output | 1 | Level interrupt request |

## Verification
Read data is due in the cycle of the access, so the bench samples `bus_rdata_o` one nanosecond after the falling edge that drives the request. Flag clearing, counter steps, reloads and the interrupt request all land at the next rising edge. They are therefore observed in the following cycle, by the next read and by the `irq_o` comparison made each cycle. A bench reference model advances once per rising edge, applying the requirement rules to the same bus and tick inputs. Every comparison is made against that model's state at the sampling point.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int RATE_W = 2;
  localparam int N_SRC  = 1 << RATE_W;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PRESET = 2'd1,
    REG_COUNT  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  localparam int B_RUN  = 0;
  localparam int B_RATE = 1;
  localparam int B_RPT  = 3;
  localparam int B_UP   = 4;
  localparam int B_STEP = 5;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;

  typedef struct packed {
    logic              ie;
    logic              up;
    logic              rpt;
    logic [RATE_W-1:0] rate;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/pic_tick_sel.sv
module pic_tick_sel import pic_pkg::*; (
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic              block_i,
  output logic              adv_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (rate_i == RATE_W'(g));
  end

  assign adv_o = run_i && (|hit) && !block_i;
endmodule

// File: rtl/pic_counter.sv
module pic_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         reload_i,
  input  logic         adv_i,
  input  logic         up_i,
  input  logic         rpt_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] preset_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q, preset_q, nxt;

  assign nxt  = up_i ? cnt_q + W'(1) : cnt_q - W'(1);
  assign tc_o = adv_i && (nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      preset_q <= '0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      preset_q <= load_val_i;
    end else if (reload_i) begin
      cnt_q <= preset_q;
    end else if (tc_o) begin
      if (rpt_i) begin
        cnt_q <= preset_q;
      end else begin
        cnt_q    <= '0;
        preset_q <= '0;
      end
    end else if (adv_i) begin
      cnt_q <= nxt;
    end
  end

  assign cnt_o    = cnt_q;
  assign preset_o = preset_q;
endmodule

// File: rtl/pic_status.sv
module pic_status import pic_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_wr_i,
  input  ctrl_t wr_ctrl_i,
  input  logic  clr_i,
  input  logic  tc_i,
  output ctrl_t ctrl_o,
  output logic  done_o,
  output logic  err_o,
  output logic  irq_o
);
  ctrl_t ctrl_q;
  logic  done_q, err_q, irq_q;
  logic  done_base, err_base, ie_eff;

  assign done_base = clr_i ? 1'b0 : done_q;
  assign err_base  = clr_i ? 1'b0 : err_q;
  assign ie_eff    = ctrl_wr_i ? wr_ctrl_i.ie : ctrl_q.ie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= wr_ctrl_i;
      else if (tc_i && !ctrl_q.rpt) ctrl_q.run <= 1'b0;

      // clear first, then terminal count sets
      done_q <= done_base || (tc_i && !done_base);
      err_q  <= err_base || (tc_i && done_base);

      if (tc_i && ie_eff) irq_q <= 1'b1;
      else if (clr_i)     irq_q <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/prog_interval_clock.sv
module prog_interval_clock import pic_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_SRC-1:0]  tick_i,
  output logic              irq_o
);
  reg_sel_e    reg_sel;
  logic        ctrl_wr, ctrl_rd, preset_wr, clr;
  ctrl_t       wr_ctrl, ctrl;
  logic        done, err, tc;
  logic        adv_tick, step_man, adv, reload, up_eff, rpt_eff;
  logic [DATA_W-1:0] cnt, preset;

  assign reg_sel   = reg_sel_e'(bus_addr_i);
  assign ctrl_wr   = bus_sel_i &&  bus_wr_i && (reg_sel == REG_CTRL);
  assign ctrl_rd   = bus_sel_i && !bus_wr_i && (reg_sel == REG_CTRL);
  assign preset_wr = bus_sel_i &&  bus_wr_i && (reg_sel == REG_PRESET);
  assign clr       = ctrl_wr || ctrl_rd || preset_wr;

  assign wr_ctrl.run  = bus_wdata_i[B_RUN];
  assign wr_ctrl.rate = bus_wdata_i[B_RATE +: RATE_W];
  assign wr_ctrl.rpt  = bus_wdata_i[B_RPT];
  assign wr_ctrl.up   = bus_wdata_i[B_UP];
  assign wr_ctrl.ie   = bus_wdata_i[B_IE];

  assign step_man = ctrl_wr && !wr_ctrl.run && bus_wdata_i[B_STEP];
  assign reload   = ctrl_wr && wr_ctrl.run && (!ctrl.run || (wr_ctrl.rate != ctrl.rate));
  assign up_eff   = ctrl_wr ? wr_ctrl.up  : ctrl.up;
  assign rpt_eff  = ctrl_wr ? wr_ctrl.rpt : ctrl.rpt;
  assign adv      = adv_tick || step_man;

  pic_tick_sel u_tick (
    .run_i   (ctrl.run),
    .rate_i  (ctrl.rate),
    .tick_i  (tick_i),
    .block_i (ctrl_wr || preset_wr),
    .adv_o   (adv_tick)
  );

  pic_counter #(.W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (preset_wr),
    .load_val_i (bus_wdata_i),
    .reload_i   (reload),
    .adv_i      (adv),
    .up_i       (up_eff),
    .rpt_i      (rpt_eff),
    .cnt_o      (cnt),
    .preset_o   (preset),
    .tc_o       (tc)
  );

  pic_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .wr_ctrl_i (wr_ctrl),
    .clr_i     (clr),
    .tc_i      (tc),
    .ctrl_o    (ctrl),
    .done_o    (done),
    .err_o     (err),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_sel)
      REG_CTRL: begin
        bus_rdata_o[B_RUN]            = ctrl.run;
        bus_rdata_o[B_RATE +: RATE_W] = ctrl.rate;
        bus_rdata_o[B_RPT]            = ctrl.rpt;
        bus_rdata_o[B_UP]             = ctrl.up;
        bus_rdata_o[B_IE]             = ctrl.ie;
        bus_rdata_o[B_DONE]           = done;
        bus_rdata_o[DATA_W-1]         = err;
      end
      REG_COUNT: bus_rdata_o = cnt;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker import pic_pkg::*; #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [1:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] preset,
  input logic              done,
  input logic              err,
  input logic              tc,
  input ctrl_t             ctrl
);
  logic acc_ctrl_wr, acc_preset_wr, acc_count_wr, acc_ctrl_rd;
  assign acc_ctrl_wr   = bus_sel_i &&  bus_wr_i && bus_addr_i == 2'd0;
  assign acc_preset_wr = bus_sel_i &&  bus_wr_i && bus_addr_i == 2'd1;
  assign acc_count_wr  = bus_sel_i &&  bus_wr_i && bus_addr_i == 2'd2;
  assign acc_ctrl_rd   = bus_sel_i && !bus_wr_i && bus_addr_i == 2'd0;

  assert_irq_held_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(acc_ctrl_wr || acc_ctrl_rd || acc_preset_wr));

  assert_err_needs_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $past(done));

  assert_preset_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_preset_wr |=> (cnt == $past(bus_wdata_i)) && (preset == $past(bus_wdata_i)));

  assert_count_wr_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_count_wr && !ctrl.run) |=> $stable(cnt));

  assert_start_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ctrl_wr && bus_wdata_i[0] && !ctrl.run) |=> cnt == $past(preset));

  assert_single_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !ctrl.rpt && !acc_ctrl_wr) |=> !ctrl.run && cnt == '0);

  assert_clear_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ctrl_rd && !tc) |=> !done && !err);
endmodule

bind prog_interval_clock pic_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .cnt         (cnt),
  .preset      (preset),
  .done        (done),
  .err         (err),
  .tc          (tc),
  .ctrl        (ctrl)
);

// File: tb/sim_prog_interval_clock.sv
`timescale 1ns/1ps
module sim_prog_interval_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [3:0]  tick = '0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // reference state
  logic m_run, m_rpt, m_up, m_ie, m_done, m_err, m_irq;
  logic [1:0]  m_rate;
  logic [15:0] m_cnt, m_pre;

  always #2.5 clk = ~clk;

  prog_interval_clock u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_i(tick), .irq_o(irq)
  );

  function automatic logic [15:0] m_read(input logic [1:0] a);
    logic [15:0] v = '0;
    if (a == 2'd0) v = {m_err, 7'd0, m_done, m_ie, 1'b0, m_up, m_rpt, m_rate, m_run};
    else if (a == 2'd2) v = m_cnt;
    return v;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_run, m_rpt, m_up, m_ie, m_done, m_err, m_irq} = '0;
    m_rate = '0; m_cnt = '0; m_pre = '0;
  endtask

  task automatic model_step(input logic s, input logic w, input logic [1:0] a,
                            input logic [15:0] d, input logic [3:0] tk);
    logic cw, pw, cr, clr, up_e, rpt_e, ie_e, adv, tc, dn, er;
    logic [15:0] nxt;
    cw = s && w && a == 2'd0; pw = s && w && a == 2'd1; cr = s && !w && a == 2'd0;
    clr = cw || pw || cr;
    up_e = cw ? d[4] : m_up; rpt_e = cw ? d[3] : m_rpt; ie_e = cw ? d[6] : m_ie;
    adv = (m_run && tk[m_rate] && !cw && !pw) || (cw && !d[0] && d[5]);
    nxt = up_e ? m_cnt + 16'd1 : m_cnt - 16'd1;
    tc = adv && nxt == 16'd0;
    dn = clr ? 1'b0 : m_done; er = clr ? 1'b0 : m_err;
    if (tc) begin if (dn) er = 1'b1; else dn = 1'b1; end
    if (tc && ie_e) m_irq = 1'b1; else if (clr) m_irq = 1'b0;
    if (pw) begin m_pre = d; m_cnt = d; end
    else if (cw && d[0] && (!m_run || d[2:1] != m_rate)) m_cnt = m_pre;
    else if (tc) begin
      if (rpt_e) m_cnt = m_pre; else begin m_cnt = '0; m_pre = '0; end
    end else if (adv) m_cnt = nxt;
    if (cw) begin
      m_run = d[0]; m_rate = d[2:1]; m_rpt = d[3]; m_up = d[4]; m_ie = d[6];
    end else if (tc && !m_rpt) m_run = 1'b0;
    m_done = dn; m_err = er;
  endtask

  task automatic cyc(input logic s, input logic w, input logic [1:0] a,
                     input logic [15:0] d, input logic [3:0] tk, input string tag);
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; tick = tk;
    #1;
    if (s && !w) check(rdata, m_read(a), tag);
    check({15'd0, irq}, {15'd0, m_irq}, "R13 irq level");
    @(posedge clk);
    model_step(s, w, a, d, tk);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 16'h0, 4'h0, tag);
  endtask
  task automatic wrr(input logic [1:0] a, input logic [15:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 4'h0, tag);
  endtask
  task automatic ticks(input int n, input logic [3:0] tk, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 16'h0, tk, tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, "R1 ctrl after reset");
    rd(2'd2, "R1 count after reset");
    rd(2'd3, "R2 unused address");

    // R5 preset load, count write ignored, preset reads zero
    wrr(2'd1, 16'd5, "R5");
    rd(2'd2, "R5 counter loaded");
    wrr(2'd2, 16'd77, "R5");
    rd(2'd2, "R5 count write ignored");
    rd(2'd1, "R2 preset reads zero");

    // R6 wrong strobe ignored, R7 single-shot terminal, R8 single stop
    wrr(2'd0, 16'h0043, "R3 start rate1 ie");
    rd(2'd0, "R3 ctrl fields");
    ticks(4, 4'b1101, "R6 other strobes");
    rd(2'd2, "R6 no count on wrong strobe");
    ticks(2, 4'b0010, "R6");
    rd(2'd2, "R6 down count");
    ticks(3, 4'b0010, "R7");
    rd(2'd0, "R7 done and R8 run cleared");
    rd(2'd0, "R4 flags cleared by read");
    rd(2'd2, "R8 single mode counter zero");

    // R8 repeat mode, R7 overrun
    wrr(2'd1, 16'd3, "R5");
    wrr(2'd0, 16'h004D, "R3 repeat rate2");
    ticks(3, 4'b0100, "R8");
    rd(2'd2, "R8 repeat reload");
    ticks(3, 4'b0100, "R7");
    rd(2'd0, "R7 overrun error");
    // R9 rate change reload
    ticks(1, 4'b0100, "R9");
    wrr(2'd0, 16'h004B, "R9 rate change");
    rd(2'd2, "R9 reload on rate change");
    // R12 terminal with read in same cycle
    ticks(2, 4'b0010, "R12");
    cyc(1'b1, 1'b0, 2'd0, 16'h0, 4'b0010, "R12 read at terminal");
    rd(2'd0, "R12 done survives clear");

    // R11 up count from FFFE
    wrr(2'd0, 16'h0000, "R3 stop");
    wrr(2'd1, 16'hFFFE, "R5");
    wrr(2'd0, 16'h0011, "R11 up start");
    ticks(1, 4'b0001, "R11");
    rd(2'd0, "R11 not yet terminal");
    ticks(1, 4'b0001, "R11");
    rd(2'd0, "R11 up wrap terminal");

    // R10 manual step
    wrr(2'd1, 16'd2, "R5");
    wrr(2'd0, 16'h0060, "R10 step down");
    rd(2'd2, "R10 stepped once");
    wrr(2'd0, 16'h0060, "R10 step to zero");
    rd(2'd0, "R10 terminal by hand");
    wrr(2'd1, 16'hFFFF, "R5");
    wrr(2'd0, 16'h0030, "R10 step up wraps");
    rd(2'd2, "R10 up step counter");

    // R11 full interval from preset zero
    wrr(2'd1, 16'd0, "R5");
    wrr(2'd0, 16'h0001, "R11 start rate0");
    ticks(65535, 4'b0001, "R11");
    rd(2'd0, "R11 no terminal at 65535");
    ticks(1, 4'b0001, "R11");
    rd(2'd0, "R11 terminal at 65536");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [15:0] d;
      logic [3:0] tk;
      op = $urandom_range(0, 19);
      tk = 4'($urandom_range(0, 15));
      d = 16'($urandom);
      if (op == 0) cyc(1'b1, 1'b1, 2'd0, d & 16'h807F, tk, "R3 random ctrl write");
      else if (op == 1) cyc(1'b1, 1'b1, 2'd1, 16'($urandom_range(0, 6)), tk, "R5 random preset");
      else if (op == 2) cyc(1'b1, 1'b1, 2'd2, d, tk, "R5 random count write");
      else if (op < 6) cyc(1'b1, 1'b0, 2'($urandom_range(0, 3)), 16'h0, tk, "R2 random read");
      else cyc(1'b0, 1'b0, 2'd0, 16'h0, tk, "R6 random ticks");
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(190000 * 5);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule